// File: doc/BRIEF.md
# Triggered Pattern Period Controller

This block sets the timing of a multi-channel waveform generator. A software run bit arms it. An external trigger, synchronized into the clock domain, then starts the pattern after a programmable delay. While the pattern is on, the controller produces a chain of back-to-back pattern periods. Each period is a 16-bit length multiplied by a prescale value, which gives the number of clocks per length unit. Per-channel logic downstream uses the one-cycle period-start strobe as the reference for its own start delay.

Three modes decide how periods are used. In continuous mode the pattern stays on and period boundaries have no effect. In endless periodic mode a strobe marks every period until the pattern stops. In finite periodic mode the pattern ends by itself after a programmed number of periods and raises a done pulse. A running pattern also stops on a new trigger rising edge, or when the run bit is cleared.

Top module: `pattern_period_ctrl`

## Requirements
- R1: After reset, pattern_on, period_start and pattern_done are all low.
- R2: With run high, a trigger rising edge starts the pattern. pattern_on goes high D+4 clock edges after the first edge that samples the trigger high: two edges to synchronize, one to detect the edge, and D+1 edges of delay, where D is start_delay.
- R3: A trigger edge while run is low has no effect, and pattern_on stays low.
- R4: A period lasts max(period_len,1) × max(prescale,1) clock cycles. In periodic modes, period_start is high for exactly one cycle at the first cycle of each period. Periods follow each other with no gap, and the first one begins in the first cycle of pattern_on.
- R5: In continuous mode (mode = 2'b00), period_start never pulses, and pattern_on stays high until the pattern is stopped.
- R6: In endless mode (mode = 2'b01, and also 2'b11), periods repeat without limit while the pattern is on.
- R7: In finite mode (mode = 2'b10), pattern_on stays high for exactly max(repeat_count,1) periods. pattern_done is then high for exactly one cycle, in the first cycle after pattern_on falls.
- R8: A trigger rising edge while the pattern is on stops it. pattern_on falls 3 edges after the first edge that samples the trigger high, and pattern_done stays low.
- R9: If run is low while the pattern is on, pattern_on is low in the next cycle and pattern_done stays low.
- R10: A period_len or prescale of zero counts as one, so every cycle becomes its own period when both are zero.
- R11: Clearing run during the start delay cancels the start, and the pattern does not come on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Arms the controller and keeps the pattern going |
| trig_in | input | 1 | Asynchronous trigger |
| prescale | input | PRESCALE_W | Clock cycles per period length unit |
| period_len | input | PERIOD_W | Period length in prescale units |
| start_delay | input | DELAY_W | Extra start delay after the trigger |
| mode | input | 2 | 00 continuous, 01/11 endless, 10 finite |
| repeat_count | input | COUNT_W | Number of periods in finite mode |
| pattern_on | output | 1 | Pattern is running |
| period_start | output | 1 | First cycle of each period |
| pattern_done | output | 1 | One-cycle pulse when a finite pattern completes |

## Verification
Stopping on a trigger is the hardest case to reach. The trigger that started the pattern must first be seen low through the whole synchronizer, so that a second rising edge can be detected while the pattern runs. Each scenario therefore drops the trigger as soon as the pattern comes on, runs several full periods, and only then raises the trigger again. Latencies are measured in edges from the drive point. Zero period and prescale values are driven together so that every cycle is a period boundary, and the strobe and the finite count are checked at that limit.

// File: rtl/pattern_period_ctrl.sv
module pattern_period_ctrl #(
  parameter int PERIOD_W   = 16,
  parameter int PRESCALE_W = 5,
  parameter int DELAY_W    = 16,
  parameter int COUNT_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  trig_in,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic [PERIOD_W-1:0]   period_len,
  input  logic [DELAY_W-1:0]    start_delay,
  input  logic [1:0]            mode,
  input  logic [COUNT_W-1:0]    repeat_count,
  output logic                  pattern_on,
  output logic                  period_start,
  output logic                  pattern_done
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ON} st_t;

  st_t                   state;
  logic [2:0]            sync;
  logic [DELAY_W-1:0]    dly_cnt;
  logic [PRESCALE_W-1:0] pre_cnt;
  logic [PERIOD_W-1:0]   per_cnt;
  logic [COUNT_W-1:0]    rep_cnt;
  logic                  done_q;

  wire trig_rise = sync[1] & ~sync[2];
  wire periodic  = (mode != 2'b00);
  wire finite    = (mode == 2'b10);

  wire [PRESCALE_W-1:0] pre_max = (prescale == '0)     ? '0 : prescale - 1'b1;
  wire [PERIOD_W-1:0]   per_max = (period_len == '0)   ? '0 : period_len - 1'b1;
  wire [COUNT_W-1:0]    rep_max = (repeat_count == '0) ? '0 : repeat_count - 1'b1;

  wire pre_last = (pre_cnt == pre_max);
  wire per_last = (per_cnt == per_max);
  wire rep_last = (rep_cnt == rep_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sync    <= '0;
      dly_cnt <= '0;
      pre_cnt <= '0;
      per_cnt <= '0;
      rep_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      sync   <= {sync[1:0], trig_in};
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run && trig_rise) begin
            state   <= ST_WAIT;
            dly_cnt <= start_delay;
          end
        end
        ST_WAIT: begin
          if (!run) begin
            state <= ST_IDLE;
          end else if (dly_cnt == '0) begin
            state   <= ST_ON;
            pre_cnt <= '0;
            per_cnt <= '0;
            rep_cnt <= '0;
          end else begin
            dly_cnt <= dly_cnt - 1'b1;
          end
        end
        ST_ON: begin
          if (!run || trig_rise) begin
            state <= ST_IDLE;
          end else if (pre_last) begin
            pre_cnt <= '0;
            if (per_last) begin
              per_cnt <= '0;
              if (finite && rep_last) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                rep_cnt <= rep_cnt + 1'b1;
              end
            end else begin
              per_cnt <= per_cnt + 1'b1;
            end
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pattern_on   = (state == ST_ON);
  assign period_start = pattern_on && periodic && (pre_cnt == '0) && (per_cnt == '0);
  assign pattern_done = done_q;
endmodule

module pattern_period_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] mode,
  input logic       pattern_on,
  input logic       period_start,
  input logic       pattern_done
);
  p_strobe_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> pattern_on);
  p_cont_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !period_start);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |=> !pattern_done);
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |-> (!pattern_on && $past(pattern_on)));
  p_run_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pattern_on && !run) |=> (!pattern_on && !pattern_done));
endmodule

bind pattern_period_ctrl pattern_period_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
  .pattern_on(pattern_on), .period_start(period_start), .pattern_done(pattern_done)
);

// File: tb/tb_pattern_period_ctrl.sv
`timescale 1ns/1ps
module tb_pattern_period_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        trig_in = 1'b0;
  logic [4:0]  prescale = '0;
  logic [15:0] period_len = '0;
  logic [15:0] start_delay = '0;
  logic [1:0]  mode = '0;
  logic [15:0] repeat_count = '0;
  logic        pattern_on, period_start, pattern_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pattern_period_ctrl dut (
    .clk(clk), .rst_n(rst_n), .run(run), .trig_in(trig_in),
    .prescale(prescale), .period_len(period_len), .start_delay(start_delay),
    .mode(mode), .repeat_count(repeat_count),
    .pattern_on(pattern_on), .period_start(period_start), .pattern_done(pattern_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_gap();
    run = 1'b0; trig_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic start_pattern(input int d, input string req);
    int lat;
    start_delay = 16'(d);
    run = 1'b1;
    repeat (4) @(negedge clk);
    trig_in = 1'b1;
    lat = 0;
    while (!pattern_on && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    trig_in = 1'b0;
    check(lat == d + 4, req, lat, d + 4);
  endtask

  task automatic period_gap(input int exp_len, input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_start && n < 5000);
    check(n == exp_len, req, n, exp_len);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!pattern_on && !period_start && !pattern_done, "R1 reset outputs", {pattern_on, period_start, pattern_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_no_run();
    int seen = 0;
    run = 1'b0; mode = 2'b01; period_len = 16'd2; prescale = 5'd1;
    trig_in = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (pattern_on) seen++;
    end
    check(seen == 0, "R3 trigger without run", seen, 0);
    idle_gap();
  endtask

  task automatic t_endless(input logic [1:0] m, input string tag);
    int k;
    mode = m; period_len = 16'd3; prescale = 5'd2;
    start_pattern(2, {"R2 start latency ", tag});
    check(period_start, "R4 strobe at first cycle", period_start, 1);
    @(negedge clk);
    check(!period_start, "R4 strobe one cycle", period_start, 0);
    period_gap(5, "R4 period length 3x2");
    for (int i = 0; i < 4; i++) period_gap(6, {"R6 endless periods ", tag});
    check(pattern_on, "R6 still on", pattern_on, 1);
    trig_in = 1'b1;
    k = 0;
    while (pattern_on && k < 100) begin
      @(negedge clk);
      k++;
      check(!pattern_done, "R8 no done on trigger stop", pattern_done, 0);
    end
    check(k == 3, "R8 trigger stop latency", k, 3);
    idle_gap();
  endtask

  task automatic t_continuous();
    int strobes = 0, off = 0;
    mode = 2'b00; period_len = 16'd2; prescale = 5'd1;
    start_pattern(0, "R2 start latency cont");
    repeat (30) begin
      if (period_start) strobes++;
      if (!pattern_on) off++;
      @(negedge clk);
    end
    check(strobes == 0, "R5 no strobe in continuous", strobes, 0);
    check(off == 0, "R5 stays on", off, 0);
    run = 1'b0;
    @(negedge clk);
    check(!pattern_on, "R9 run clear stops", pattern_on, 0);
    check(!pattern_done, "R9 no done", pattern_done, 0);
    idle_gap();
  endtask

  task automatic t_finite(input int n, input int p, input int s, input string req);
    int len = 1, strobes = 0, nexp, lexp;
    lexp = (p == 0 ? 1 : p) * (s == 0 ? 1 : s);
    nexp = (n == 0 ? 1 : n);
    mode = 2'b10; repeat_count = 16'(n); period_len = 16'(p); prescale = 5'(s);
    start_pattern(1, {"R2 start latency ", req});
    if (period_start) strobes++;
    forever begin
      @(negedge clk);
      if (!pattern_on || len > 5000) break;
      len++;
      if (period_start) strobes++;
    end
    check(len == nexp * lexp, {req, " on length"}, len, nexp * lexp);
    check(strobes == nexp, {req, " strobe count"}, strobes, nexp);
    check(pattern_done, "R7 done after last period", pattern_done, 1);
    @(negedge clk);
    check(!pattern_done, "R7 done one cycle", pattern_done, 0);
    check(!pattern_on, "R7 stays off", pattern_on, 0);
    idle_gap();
  endtask

  task automatic t_abort();
    int seen = 0;
    mode = 2'b01; period_len = 16'd2; prescale = 5'd1; start_delay = 16'd10;
    run = 1'b1;
    repeat (4) @(negedge clk);
    trig_in = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    trig_in = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (pattern_on) seen++;
    end
    check(seen == 0, "R11 run clear during delay", seen, 0);
    idle_gap();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_run();
    t_endless(2'b01, "mode01");
    t_endless(2'b11, "mode11");
    t_continuous();
    t_finite(3, 2, 3, "R7 finite 3x6");
    t_finite(2, 0, 0, "R10 zero period");
    t_finite(0, 1, 2, "R7 zero count");
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule